// File: doc/BRIEF.md
# Rail Overcurrent Fault Detector

This block guards up to four power stages against overcurrent. Each stage is assigned to one of several voltage rails by a configuration field. Faults are detected on three paths. The first is an external fault line for each rail, which configuration can disable. The second is a fast compare of each stage's quantized sense level against that stage's own 6-bit threshold code; the 64 codes span roughly 31 mV to 2 V. The third is a slow path. It scales each digitized stage current by a gain and an offset, adds up the stages on each rail, smooths that rail total with a first-order filter, and compares the result with a rail limit once per sample strobe.

When a rail faults, the PWM and synchronous-rectifier enables of every stage on that rail are forced low. Stages on other rails keep following their requests. A per-rail fault latch holds the shutdown until a clear pulse arrives for that rail. For the slow path, a per-rail response setting chooses between shutting the rail down and raising a status flag only.

Top module: `rail_oc_detect`

## Requirements
- R1: After reset, every fault and warning flag reads 0 and every rail's filtered current is 0.
- R2: While a rail's external fault input is high and its enable bit is 1, the enables of that rail's stages are 0 in the same cycle. The rail's fault flag reads 1 from the next cycle.
- R3: While a rail's external-fault enable bit is 0, its external fault input has no effect on enables or flags.
- R4: A stage trips when its 6-bit sense code is strictly greater than its 6-bit threshold code. The trip forces its rail's enables low in the same cycle and sets the rail's fault flag on the next cycle. Equal codes do not trip.
- R5: A stage enable output is its request input ANDed with "the stage's rail is not faulted". A fault removes only the stages whose 1-bit rail field (stage s at bit s) names the faulted rail.
- R6: A stage's scaled current is ((adc × gain) >> 6) + offset, with all three operands unsigned. A rail's input sample is the sum of the scaled currents of the stages mapped to it.
- R7: On a sample strobe, each rail's filtered value y becomes y + floor((x − y) / 2^k), where x is the rail sum and k is the shift input. Without a strobe, y is held.
- R8: The slow compare runs only on a strobe, using the updated filter value. It trips only when that value is strictly greater than the rail limit. With response 0, a trip sets the rail's fault flag on the next cycle.
- R9: With response 1, a slow trip sets the rail's warning flag on the next cycle. It leaves the fault flag and the stage enables unaffected.
- R10: Fault and warning flags stay set until a clear pulse for that rail. When a clear and a new trip arrive in the same cycle, the flag stays set. A clear affects only its own rail.
- R11: While a rail's fault flag is set, all enables of its stages are 0, whatever the requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stage_rail_i | input | NUM_STAGES*RAIL_W | Rail index of each stage |
| ext_fault_i | input | NUM_RAILS | External fault line per rail |
| ext_en_i | input | NUM_RAILS | Enable for each external fault line |
| fast_sense_i | input | NUM_STAGES*THR_W | Quantized fast sense level per stage |
| fast_thr_i | input | NUM_STAGES*THR_W | Fast threshold code per stage |
| adc_valid_i | input | 1 | Sample strobe for the slow path |
| adc_i | input | NUM_STAGES*ADC_W | Digitized current per stage |
| gain_i | input | NUM_STAGES*GAIN_W | Scale gain per stage, 6 fraction bits |
| offset_i | input | NUM_STAGES*OFS_W | Scale offset per stage |
| filt_shift_i | input | KSH_W | Filter shift k |
| rail_limit_i | input | NUM_RAILS*SUM_W | Slow-path limit per rail |
| resp_mode_i | input | NUM_RAILS | Slow-trip response: 0 shutdown, 1 flag only |
| clear_i | input | NUM_RAILS | Clear pulse per rail |
| pwm_req_i | input | NUM_STAGES | PWM enable request per stage |
| sr_req_i | input | NUM_STAGES | Rectifier enable request per stage |
| pwm_en_o | output | NUM_STAGES | Gated PWM enable per stage |
| sr_en_o | output | NUM_STAGES | Gated rectifier enable per stage |
| fault_o | output | NUM_RAILS | Latched fault flag per rail |
| warn_o | output | NUM_RAILS | Latched slow-trip warning per rail |

## Verification
The assertions assume the following about the inputs:
- every stage's rail field names an existing rail;
- a clear pulse lasts a single cycle;
- configuration inputs may change on any cycle.

Some properties also assume a clear cannot drop a fault while an immediate trip or a strobe is present; those properties are conditioned on that. The stimulus writes only rail indices 0 and 1, which fit the default two rails. It sets slow-path limits from the bench's own predicted filter value, at exactly that value and one below it, so both sides of the strict compare occur. It then mixes random strobes, trips and clears so that clears coincide with new trips.

// File: rtl/ocd_pkg.sv
// Shared types and helpers for the rail overcurrent detector.
package ocd_pkg;

    // Response selected for a slow-path trip on one rail.
    typedef enum logic {
        RESP_SHUTDOWN  = 1'b0,
        RESP_FLAG_ONLY = 1'b1
    } resp_e;

    // Width of an index field able to name n items (at least one bit).
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/ocd_stage_scale.sv
// Scales one digitized stage current: ((adc * gain) >> GAIN_FRAC) + offset.
// Assumes unsigned operands and OFS_W no wider than the scaled result.
module ocd_stage_scale #(
    parameter int ADC_W     = 12,
    parameter int GAIN_W    = 8,
    parameter int GAIN_FRAC = 6,
    parameter int OFS_W     = 12,
    localparam int SCL_W    = ADC_W + GAIN_W - GAIN_FRAC + 1
) (
    input  logic [ADC_W-1:0]  adc_i,
    input  logic [GAIN_W-1:0] gain_i,
    input  logic [OFS_W-1:0]  ofs_i,
    output logic [SCL_W-1:0]  scaled_o
);
    localparam int PW = ADC_W + GAIN_W + 1;

    logic [PW-1:0] prod;

    // Full-precision product, then drop fraction bits and add offset.
    always_comb begin
        prod     = PW'(adc_i) * PW'(gain_i);
        scaled_o = SCL_W'((prod >> GAIN_FRAC) + PW'(ofs_i));
    end
endmodule

// File: rtl/ocd_rail_filter.sv
// Sums the scaled currents of the stages mapped to rail RAIL_ID, smooths the
// sum with y += (x - y) >>> k on each strobe, and flags a trip when the
// updated value exceeds the limit. Assumes SUM_W holds the largest rail sum.
module ocd_rail_filter #(
    parameter int NUM_STAGES = 4,
    parameter int RAIL_W     = 1,
    parameter int SCL_W      = 15,
    parameter int SUM_W      = 17,
    parameter int KSH_W      = 3,
    parameter int RAIL_ID    = 0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sample_i,
    input  logic [NUM_STAGES*SCL_W-1:0] scaled_i,
    input  logic [NUM_STAGES*RAIL_W-1:0] stage_rail_i,
    input  logic [KSH_W-1:0]            shift_i,
    input  logic [SUM_W-1:0]            limit_i,
    output logic                        trip_o
);
    logic [SUM_W-1:0]        rail_sum;
    logic [SUM_W-1:0]        y_q;
    logic [SUM_W-1:0]        y_nx;
    logic signed [SUM_W:0]   diff;
    logic signed [SUM_W:0]   step;

    // Add up the scaled currents of this rail's stages.
    always_comb begin
        rail_sum = '0;
        for (int s = 0; s < NUM_STAGES; s++) begin
            if (stage_rail_i[s*RAIL_W +: RAIL_W] == RAIL_W'(RAIL_ID))
                rail_sum = rail_sum + SUM_W'(scaled_i[s*SCL_W +: SCL_W]);
        end
    end

    // Next filter value and strict compare against the limit.
    always_comb begin
        diff   = $signed({1'b0, rail_sum}) - $signed({1'b0, y_q});
        step   = diff >>> shift_i;
        y_nx   = SUM_W'($signed({1'b0, y_q}) + step);
        trip_o = sample_i && (y_nx > limit_i);
    end

    // Filter state advances only on a sample strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            y_q <= '0;
        else if (sample_i)
            y_q <= y_nx;
    end
endmodule

// File: rtl/ocd_fault_latch.sv
// Per-rail sticky flags. Immediate trips and shutdown-mode slow trips set the
// fault flag; flag-only slow trips set the warning flag. A set wins over a
// clear in the same cycle.
module ocd_fault_latch
    import ocd_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  imm_trip_i,
    input  logic  slow_trip_i,
    input  resp_e mode_i,
    input  logic  clear_i,
    output logic  fault_o,
    output logic  warn_o
);
    logic set_fault;
    logic set_warn;

    // Route a slow trip by the selected response.
    always_comb begin
        set_fault = imm_trip_i || (slow_trip_i && (mode_i == RESP_SHUTDOWN));
        set_warn  = slow_trip_i && (mode_i == RESP_FLAG_ONLY);
    end

    // Hold flags until cleared; new sets take priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_o <= 1'b0;
            warn_o  <= 1'b0;
        end else begin
            fault_o <= (fault_o && !clear_i) || set_fault;
            warn_o  <= (warn_o && !clear_i) || set_warn;
        end
    end
endmodule

// File: rtl/rail_oc_detect.sv
// Top of the rail overcurrent detector. Combines external, fast and slow
// fault paths per rail and gates each stage's PWM and rectifier enables by
// the state of the stage's rail. Assumes every rail field is < NUM_RAILS.
module rail_oc_detect
    import ocd_pkg::*;
#(
    parameter int NUM_STAGES = 4,
    parameter int NUM_RAILS  = 2,
    parameter int ADC_W      = 12,
    parameter int GAIN_W     = 8,
    parameter int GAIN_FRAC  = 6,
    parameter int OFS_W      = 12,
    parameter int THR_W      = 6,
    parameter int KSH_W      = 3,
    localparam int RAIL_W    = idx_w(NUM_RAILS),
    localparam int SCL_W     = ADC_W + GAIN_W - GAIN_FRAC + 1,
    localparam int SUM_W     = SCL_W + $clog2(NUM_STAGES)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_STAGES*RAIL_W-1:0]  stage_rail_i,
    input  logic [NUM_RAILS-1:0]          ext_fault_i,
    input  logic [NUM_RAILS-1:0]          ext_en_i,
    input  logic [NUM_STAGES*THR_W-1:0]   fast_sense_i,
    input  logic [NUM_STAGES*THR_W-1:0]   fast_thr_i,
    input  logic                          adc_valid_i,
    input  logic [NUM_STAGES*ADC_W-1:0]   adc_i,
    input  logic [NUM_STAGES*GAIN_W-1:0]  gain_i,
    input  logic [NUM_STAGES*OFS_W-1:0]   offset_i,
    input  logic [KSH_W-1:0]              filt_shift_i,
    input  logic [NUM_RAILS*SUM_W-1:0]    rail_limit_i,
    input  logic [NUM_RAILS-1:0]          resp_mode_i,
    input  logic [NUM_RAILS-1:0]          clear_i,
    input  logic [NUM_STAGES-1:0]         pwm_req_i,
    input  logic [NUM_STAGES-1:0]         sr_req_i,
    output logic [NUM_STAGES-1:0]         pwm_en_o,
    output logic [NUM_STAGES-1:0]         sr_en_o,
    output logic [NUM_RAILS-1:0]          fault_o,
    output logic [NUM_RAILS-1:0]          warn_o
);
    logic [NUM_STAGES*SCL_W-1:0] scaled;
    logic [NUM_STAGES-1:0]       fast_trip;
    logic [NUM_RAILS-1:0]        imm_trip;
    logic [NUM_RAILS-1:0]        slow_trip;
    logic [NUM_RAILS-1:0]        rail_kill;

    genvar gs, gr;

    // Per-stage scaling and fast compare.
    generate
        for (gs = 0; gs < NUM_STAGES; gs++) begin : g_stage
            ocd_stage_scale #(
                .ADC_W(ADC_W), .GAIN_W(GAIN_W),
                .GAIN_FRAC(GAIN_FRAC), .OFS_W(OFS_W)
            ) u_scale (
                .adc_i   (adc_i[gs*ADC_W +: ADC_W]),
                .gain_i  (gain_i[gs*GAIN_W +: GAIN_W]),
                .ofs_i   (offset_i[gs*OFS_W +: OFS_W]),
                .scaled_o(scaled[gs*SCL_W +: SCL_W])
            );
            assign fast_trip[gs] =
                fast_sense_i[gs*THR_W +: THR_W] > fast_thr_i[gs*THR_W +: THR_W];
        end
    endgenerate

    // Gather immediate trips (external line and fast compares) per rail.
    always_comb begin
        imm_trip = ext_fault_i & ext_en_i;
        for (int s = 0; s < NUM_STAGES; s++) begin
            if (fast_trip[s])
                imm_trip[stage_rail_i[s*RAIL_W +: RAIL_W]] = 1'b1;
        end
    end

    // Per-rail slow path and sticky flags.
    generate
        for (gr = 0; gr < NUM_RAILS; gr++) begin : g_rail
            ocd_rail_filter #(
                .NUM_STAGES(NUM_STAGES), .RAIL_W(RAIL_W), .SCL_W(SCL_W),
                .SUM_W(SUM_W), .KSH_W(KSH_W), .RAIL_ID(gr)
            ) u_filt (
                .clk         (clk),
                .rst_n       (rst_n),
                .sample_i    (adc_valid_i),
                .scaled_i    (scaled),
                .stage_rail_i(stage_rail_i),
                .shift_i     (filt_shift_i),
                .limit_i     (rail_limit_i[gr*SUM_W +: SUM_W]),
                .trip_o      (slow_trip[gr])
            );
            ocd_fault_latch u_latch (
                .clk        (clk),
                .rst_n      (rst_n),
                .imm_trip_i (imm_trip[gr]),
                .slow_trip_i(slow_trip[gr]),
                .mode_i     (resp_e'(resp_mode_i[gr])),
                .clear_i    (clear_i[gr]),
                .fault_o    (fault_o[gr]),
                .warn_o     (warn_o[gr])
            );
        end
    endgenerate

    // A rail is shut while latched or while an immediate trip is present.
    assign rail_kill = fault_o | imm_trip;

    // Gate each stage's enables by its rail's shutdown state.
    always_comb begin
        for (int s = 0; s < NUM_STAGES; s++) begin
            pwm_en_o[s] = pwm_req_i[s] && !rail_kill[stage_rail_i[s*RAIL_W +: RAIL_W]];
            sr_en_o[s]  = sr_req_i[s]  && !rail_kill[stage_rail_i[s*RAIL_W +: RAIL_W]];
        end
    end
endmodule

// File: rtl/rail_oc_detect_chk.sv
// Property checker for rail_oc_detect, attached by the bind at the bottom.
// Assumes rail fields name existing rails.
module rail_oc_detect_chk #(
    parameter int NUM_STAGES = 4,
    parameter int NUM_RAILS  = 2,
    parameter int RAIL_W     = 1
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [NUM_STAGES*RAIL_W-1:0]  stage_rail_i,
    input logic [NUM_RAILS-1:0]          ext_fault_i,
    input logic [NUM_RAILS-1:0]          ext_en_i,
    input logic [NUM_RAILS-1:0]          clear_i,
    input logic [NUM_RAILS-1:0]          resp_mode_i,
    input logic                          adc_valid_i,
    input logic [NUM_STAGES-1:0]         pwm_req_i,
    input logic [NUM_STAGES-1:0]         sr_req_i,
    input logic [NUM_STAGES-1:0]         pwm_en_o,
    input logic [NUM_STAGES-1:0]         sr_en_o,
    input logic [NUM_RAILS-1:0]          fault_o,
    input logic [NUM_RAILS-1:0]          warn_o,
    input logic [NUM_RAILS-1:0]          imm_trip
);
    genvar r, s;
    generate
        for (r = 0; r < NUM_RAILS; r++) begin : g_r
            p_ext_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (ext_en_i[r] && ext_fault_i[r]) |=> fault_o[r]);
            p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
                (fault_o[r] && !clear_i[r]) |=> fault_o[r]);
            p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
                (clear_i[r] && !imm_trip[r] && !adc_valid_i) |=> (!fault_o[r] && !warn_o[r]));
            p_flag_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (!fault_o[r] && !imm_trip[r] && resp_mode_i[r]) |=> !fault_o[r]);
            p_strobe_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (!adc_valid_i && !warn_o[r]) |=> !warn_o[r]);
        end
        for (s = 0; s < NUM_STAGES; s++) begin : g_s
            p_latched_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
                fault_o[stage_rail_i[s*RAIL_W +: RAIL_W]] |-> (!pwm_en_o[s] && !sr_en_o[s]));
            p_req_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (pwm_en_o[s] |-> pwm_req_i[s]) and (sr_en_o[s] |-> sr_req_i[s]));
        end
    endgenerate
endmodule

bind rail_oc_detect rail_oc_detect_chk #(
    .NUM_STAGES(NUM_STAGES), .NUM_RAILS(NUM_RAILS), .RAIL_W(RAIL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .stage_rail_i(stage_rail_i),
    .ext_fault_i(ext_fault_i), .ext_en_i(ext_en_i), .clear_i(clear_i),
    .resp_mode_i(resp_mode_i), .adc_valid_i(adc_valid_i),
    .pwm_req_i(pwm_req_i), .sr_req_i(sr_req_i),
    .pwm_en_o(pwm_en_o), .sr_en_o(sr_en_o),
    .fault_o(fault_o), .warn_o(warn_o), .imm_trip(imm_trip)
);

// File: tb/rail_oc_detect_test.sv
// Bench with a behavioural per-cycle reference model, compared every clock.
module rail_oc_detect_test;
    localparam int PERIOD = 10;
    localparam int NS = 4, NR = 2, SUM_W = 17;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NS-1:0]      stage_rail_i;
    logic [NR-1:0]      ext_fault_i, ext_en_i, resp_mode_i, clear_i;
    logic [NS*6-1:0]    fast_sense_i, fast_thr_i;
    logic               adc_valid_i;
    logic [NS*12-1:0]   adc_i, offset_i;
    logic [NS*8-1:0]    gain_i;
    logic [2:0]         filt_shift_i;
    logic [NR*SUM_W-1:0] rail_limit_i;
    logic [NS-1:0]      pwm_req_i, sr_req_i, pwm_en_o, sr_en_o;
    logic [NR-1:0]      fault_o, warn_o;

    rail_oc_detect uut (.*);

    always #(PERIOD/2) clk = ~clk;

    // Stimulus state and model state.
    int map[NS], sense[NS], thr[NS], adc[NS], gain[NS], ofs[NS], lim[NR];
    bit ext[NR], exten[NR], clr[NR], mode[NR], rq_p[NS], rq_s[NS];
    bit valid; int k;
    int my[NR]; bit mf[NR], mw[NR];
    int checks = 0, fails = 0; bit done = 0;

    function automatic int rail_x(int r);
        int x = 0;
        for (int s = 0; s < NS; s++)
            if (map[s] == r) x += ((adc[s] * gain[s]) >> 6) + ofs[s];
        return x;
    endfunction

    function automatic int ynext(int r);
        int d = rail_x(r) - my[r];
        return my[r] + (d >>> k);
    endfunction

    task automatic drive();
        for (int s = 0; s < NS; s++) begin
            stage_rail_i[s] = map[s][0];
            fast_sense_i[s*6 +: 6] = sense[s][5:0];
            fast_thr_i[s*6 +: 6]   = thr[s][5:0];
            adc_i[s*12 +: 12]      = adc[s][11:0];
            gain_i[s*8 +: 8]       = gain[s][7:0];
            offset_i[s*12 +: 12]   = ofs[s][11:0];
            pwm_req_i[s] = rq_p[s]; sr_req_i[s] = rq_s[s];
        end
        for (int r = 0; r < NR; r++) begin
            ext_fault_i[r] = ext[r]; ext_en_i[r] = exten[r];
            resp_mode_i[r] = mode[r]; clear_i[r] = clr[r];
            rail_limit_i[r*SUM_W +: SUM_W] = lim[r][SUM_W-1:0];
        end
        adc_valid_i = valid; filt_shift_i = k[2:0];
    endtask

    task automatic cmp(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive, compare outputs, advance model, cross the edge.
    task automatic step(string tag);
        bit imm[NR]; bit trip; int yn;
        logic [NS-1:0] ep, es; logic [NR-1:0] ef, ew;
        drive();
        #1;
        for (int r = 0; r < NR; r++) imm[r] = ext[r] && exten[r];
        for (int s = 0; s < NS; s++) if (sense[s] > thr[s]) imm[map[s]] = 1;
        for (int s = 0; s < NS; s++) begin
            ep[s] = rq_p[s] && !(mf[map[s]] || imm[map[s]]);
            es[s] = rq_s[s] && !(mf[map[s]] || imm[map[s]]);
        end
        for (int r = 0; r < NR; r++) begin ef[r] = mf[r]; ew[r] = mw[r]; end
        cmp(tag, "pwm_en", int'(pwm_en_o), int'(ep));
        cmp(tag, "sr_en",  int'(sr_en_o),  int'(es));
        cmp(tag, "fault",  int'(fault_o),  int'(ef));
        cmp(tag, "warn",   int'(warn_o),   int'(ew));
        for (int r = 0; r < NR; r++) begin
            trip = 0;
            if (valid) begin yn = ynext(r); trip = yn > lim[r]; my[r] = yn; end
            mf[r] = (mf[r] && !clr[r]) || imm[r] || (trip && !mode[r]);
            mw[r] = (mw[r] && !clr[r]) || (trip && mode[r]);
        end
        @(posedge clk); @(negedge clk);
        for (int r = 0; r < NR; r++) clr[r] = 0;
        valid = 0;
    endtask

    task automatic clear_all(string tag);
        clr[0] = 1; clr[1] = 1; step(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < NS; s++) begin
            map[s] = s / 2; sense[s] = 10; thr[s] = 40; adc[s] = 0;
            gain[s] = 64; ofs[s] = 0; rq_p[s] = 1; rq_s[s] = 1;
        end
        for (int r = 0; r < NR; r++) begin
            lim[r] = 100000; ext[r] = 0; exten[r] = 1; clr[r] = 0; mode[r] = 0;
            my[r] = 0; mf[r] = 0; mw[r] = 0;
        end
        valid = 0; k = 2;
        drive();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: flags clear after reset, filter starts at zero (checked by R7 later)
        repeat (3) step("R1");

        // R2: external fault on rail 1, then latched shutdown (R11)
        ext[1] = 1; step("R2");
        ext[1] = 0; rq_p[2] = 0; step("R11"); rq_p[2] = 1; step("R11");
        clr[1] = 1; step("R10"); step("R10");

        // R3: disabled external line is ignored
        exten[0] = 0; ext[0] = 1; repeat (3) step("R3");
        ext[0] = 0; exten[0] = 1; step("R3");

        // R4: equal code does not trip, one above does
        sense[2] = 40; step("R4");
        sense[2] = 41; step("R4");
        sense[2] = 10; step("R4"); step("R4");
        clr[1] = 1; step("R10");

        // R5: remap and check only the faulted rail's stages drop
        map[2] = 0; sense[3] = 63; thr[3] = 62;
        rq_p = '{1, 0, 1, 0}; rq_s = '{0, 1, 1, 1}; step("R5");
        sense[3] = 10; rq_p = '{0, 1, 0, 1}; step("R5");
        clear_all("R5");
        map[2] = 1; thr[3] = 40; rq_p = '{1, 1, 1, 1}; rq_s = '{1, 1, 1, 1};

        // R6/R7: filter tracked exactly by bracketing the limit
        mode[0] = 1; mode[1] = 1;
        adc = '{1000, 2000, 300, 4095}; gain = '{64, 32, 100, 255};
        ofs = '{5, 0, 17, 4095};
        for (int i = 0; i < 12; i++) begin
            k = (i < 4) ? 2 : ((i < 8) ? 0 : 7);
            if (i == 6) adc = '{10, 4000, 0, 100};
            for (int r = 0; r < NR; r++) lim[r] = ynext(r);
            valid = 1; step("R7");
            for (int r = 0; r < NR; r++) lim[r] = ynext(r) - 1;
            valid = 1; step("R6");
            step("R8");
            clear_all("R7");
        end
        // R8: no compare without a strobe
        lim[0] = 0; lim[1] = 0; repeat (3) step("R8");

        // R9: flag-only response on rail 0
        valid = 1; step("R9"); step("R9");
        clear_all("R9");
        // R8: shutdown response on rail 1
        mode[1] = 0; valid = 1; step("R8"); step("R8");
        clear_all("R8");

        // R10: clear with simultaneous trip, clear is per rail
        lim[0] = 100000; lim[1] = 100000;
        ext[0] = 1; ext[1] = 1; step("R10");
        ext[1] = 0; clr[0] = 1; step("R10");
        ext[0] = 0; step("R10");
        clr[1] = 1; step("R10"); step("R10");
        clear_all("R10");

        // Random mix of all paths
        for (int i = 0; i < 600; i++) begin
            for (int s = 0; s < NS; s++) begin
                map[s] = $urandom_range(0, 1);
                thr[s] = $urandom_range(45, 63); sense[s] = $urandom_range(0, 63);
                adc[s] = $urandom_range(0, 4095); gain[s] = $urandom_range(0, 255);
                ofs[s] = $urandom_range(0, 4095);
                rq_p[s] = $urandom_range(0, 1); rq_s[s] = $urandom_range(0, 1);
            end
            for (int r = 0; r < NR; r++) begin
                ext[r] = ($urandom_range(0, 15) == 0); exten[r] = $urandom_range(0, 1);
                mode[r] = $urandom_range(0, 1); clr[r] = ($urandom_range(0, 5) == 0);
                lim[r] = $urandom_range(0, 60000);
            end
            valid = ($urandom_range(0, 2) == 0); k = $urandom_range(0, 7);
            step("R5");
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule